// File: doc/BRIEF.md
# Switching Waveform Parameter Extractor

This block takes one reconstructed switching period of a power transistor, held as three parallel sample streams (gate voltage, drain voltage, drain current, each a 16-bit converter code on a 3.3 V scale). It derives the raw quantities that later arithmetic turns into device figures of merit. It stores the period in an internal sample buffer, which is filled through a simple write port while the block is idle. A start pulse then runs two sequential scans over the buffer, reading one sample per clock.

The first scan finds the gate minimum and maximum. It also finds the gate code at which drain current first reaches a programmed constant level, which is the constant-current threshold. The level is normally set to about a hundred times the current measurement uncertainty. The same scan accumulates on-state drain voltage and drain current over a programmed conduction window, as two sums and one count.

The second scan measures the gate charging time constant in sample intervals. The rise is taken to start at the first sample that lies above the minimum by a noise margin. It ends at the first sample at or after that start that reaches 63% of the gate span. All results are registered and presented together with a single-cycle done flag. Dividing the sums, and scaling to ohms or farads, are left to downstream logic.

Top module: `wfx_top`

## Requirements
- R1: After synchronous reset, busy, done, tau_ok and vth_ok are 0, and tau, vth, sum_vd, sum_id and on_cnt are 0.
- R2: A start sampled while idle raises busy from the next cycle. done is a one-cycle pulse that appears on the (2·N_SAMP+5)th rising edge after the edge that sampled start. On that same edge busy falls and all result outputs update. The results then hold until the next done.
- R3: While busy, start pulses, buffer writes and changes to the cfg_* inputs have no effect. The configuration is captured on the edge that accepts start.
- R4: The 63% level is gmin + floor((gmax − gmin)·161/256), where gmin and gmax are the smallest and largest gate codes in the buffer.
- R5: The rise start is the lowest index whose gate code exceeds gmin + cfg_margin, computed without overflow. The crossing is the lowest index at or after the rise start whose gate code is at least the 63% level. tau is the crossing index minus the start index, with tau_ok = 1.
- R6: If no rise start or no crossing exists, tau_ok = 0 and tau = 0.
- R7: vth is the gate code at the lowest index whose drain current code is at least cfg_ilevel, with vth_ok = 1.
- R8: If no sample reaches cfg_ilevel, vth_ok = 0 and vth = 0.
- R9: sum_vd and sum_id are the sums of drain voltage and drain current codes over indices cfg_on_first to cfg_on_last inclusive, and on_cnt is the number of those indices. If cfg_on_first > cfg_on_last, all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Buffer write strobe (honoured only while idle) |
| wr_addr | input | AW | Sample index to write |
| wr_gate | input | SW | Gate voltage code |
| wr_vd | input | SW | Drain voltage code |
| wr_id | input | SW | Drain current code |
| start | input | 1 | Begin extraction |
| cfg_margin | input | SW | Noise margin above the gate minimum for the rise start |
| cfg_ilevel | input | SW | Drain current level for the threshold crossing |
| cfg_on_first | input | AW | First index of the conduction window |
| cfg_on_last | input | AW | Last index of the conduction window |
| busy | output | 1 | Extraction in progress |
| done | output | 1 | One-cycle result strobe |
| tau | output | AW | Gate time constant in sample intervals |
| tau_ok | output | 1 | tau is valid |
| vth | output | SW | Gate code at the current-level crossing |
| vth_ok | output | 1 | vth is valid |
| sum_vd | output | SW+CW | On-window drain voltage sum |
| sum_id | output | SW+CW | On-window drain current sum |
| on_cnt | output | CW | Number of on-window samples |

## Verification
The assertions take it for granted that reset is applied before the first start. They also assume the buffer holds at least one sample, so the minimum and maximum are defined before the timing scan reads them. The bench respects this by loading a complete period before every start. The sweep covers flat, falling, saturated and pseudo-random gate shapes, margins that leave no rise start, and current levels reached at index zero or never. One run deliberately drives writes, a second start and new configuration values in mid-scan. A repeat run afterwards shows that both the buffer and the captured configuration were left intact.

// File: rtl/wfx_pkg.sv
package wfx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STAT,
    ST_TIME,
    ST_FIN
  } wfx_state_e;
endpackage

// File: rtl/wfx_buffer.sv
module wfx_buffer #(
  parameter int DW    = 48,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/wfx_stat_scan.sv
module wfx_stat_scan #(
  parameter int SW   = 16,
  parameter int AW   = 6,
  parameter int CW   = 7,
  parameter int SUMW = SW + CW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            vld,
  input  logic [AW-1:0]   idx,
  input  logic [SW-1:0]   gate,
  input  logic [SW-1:0]   vd,
  input  logic [SW-1:0]   id,
  input  logic [SW-1:0]   ilevel,
  input  logic [AW-1:0]   on_first,
  input  logic [AW-1:0]   on_last,
  output logic [SW-1:0]   gmin,
  output logic [SW-1:0]   gmax,
  output logic            hit,
  output logic [SW-1:0]   vth,
  output logic [SUMW-1:0] sum_vd,
  output logic [SUMW-1:0] sum_id,
  output logic [CW-1:0]   on_cnt
);
  logic in_win;
  assign in_win = (idx >= on_first) && (idx <= on_last);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      gmin   <= '1;
      gmax   <= '0;
      hit    <= 1'b0;
      vth    <= '0;
      sum_vd <= '0;
      sum_id <= '0;
      on_cnt <= '0;
    end else if (vld) begin
      if (gate < gmin) gmin <= gate;
      if (gate > gmax) gmax <= gate;
      if (!hit && (id >= ilevel)) begin
        hit <= 1'b1;
        vth <= gate;
      end
      if (in_win) begin
        sum_vd <= sum_vd + {{CW{1'b0}}, vd};
        sum_id <= sum_id + {{CW{1'b0}}, id};
        on_cnt <= on_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wfx_rise_scan.sv
module wfx_rise_scan #(
  parameter int SW = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          vld,
  input  logic [AW-1:0] idx,
  input  logic [SW-1:0] gate,
  input  logic [SW:0]   lo_mark,
  input  logic [SW-1:0] hi_mark,
  output logic          found,
  output logic [AW-1:0] tau
);
  logic          started;
  logic [AW-1:0] t0;
  logic          above_lo, started_now;

  assign above_lo    = {1'b0, gate} > lo_mark;
  assign started_now = started || above_lo;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      started <= 1'b0;
      t0      <= '0;
      found   <= 1'b0;
      tau     <= '0;
    end else if (vld) begin
      if (!started && above_lo) begin
        started <= 1'b1;
        t0      <= idx;
      end
      if (!found && started_now && (gate >= hi_mark)) begin
        found <= 1'b1;
        tau   <= started ? (idx - t0) : '0;
      end
    end
  end

  // R5
  found_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    found |-> started);
endmodule

// File: rtl/wfx_top.sv
module wfx_top #(
  parameter int N_SAMP = 64,
  parameter int SW     = 16,
  localparam int AW    = $clog2(N_SAMP),
  localparam int CW    = $clog2(N_SAMP + 1),
  localparam int SUMW  = SW + CW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [SW-1:0]   wr_gate,
  input  logic [SW-1:0]   wr_vd,
  input  logic [SW-1:0]   wr_id,
  input  logic            start,
  input  logic [SW-1:0]   cfg_margin,
  input  logic [SW-1:0]   cfg_ilevel,
  input  logic [AW-1:0]   cfg_on_first,
  input  logic [AW-1:0]   cfg_on_last,
  output logic            busy,
  output logic            done,
  output logic [AW-1:0]   tau,
  output logic            tau_ok,
  output logic [SW-1:0]   vth,
  output logic            vth_ok,
  output logic [SUMW-1:0] sum_vd,
  output logic [SUMW-1:0] sum_id,
  output logic [CW-1:0]   on_cnt
);
  import wfx_pkg::*;

  localparam int DW = 3 * SW;

  function automatic logic [SW-1:0] level63(input logic [SW-1:0] lo, input logic [SW-1:0] hi);
    logic [SW+7:0] prod;
    prod = {8'd0, hi - lo} * (SW+8)'(161);
    return lo + prod[SW+7:8];
  endfunction

  wfx_state_e    state;
  logic [CW-1:0] cnt;
  logic          issue, d_vld;
  logic [AW-1:0] d_idx;
  logic          buf_we;
  logic [DW-1:0] rdata;
  logic [SW-1:0] r_gate, r_vd, r_id;
  logic [SW-1:0] k_margin, k_ilevel;
  logic [AW-1:0] k_first, k_last;
  logic          clr_stat, clr_rise, pass_end;

  logic [SW-1:0]   gmin, gmax, s_vth;
  logic            s_hit;
  logic [SUMW-1:0] s_svd, s_sid;
  logic [CW-1:0]   s_cnt;
  logic            r_found;
  logic [AW-1:0]   r_tau;
  logic [SW:0]     lo_mark;
  logic [SW-1:0]   hi_mark;

  assign issue    = ((state == ST_STAT) || (state == ST_TIME)) && (cnt < CW'(N_SAMP));
  assign pass_end = !issue && !d_vld;
  assign buf_we   = wr_en && (state == ST_IDLE);
  assign clr_stat = (state == ST_IDLE) && start;
  assign clr_rise = (state == ST_STAT) && pass_end;
  assign busy     = (state != ST_IDLE);
  assign {r_gate, r_vd, r_id} = rdata;
  assign lo_mark  = {1'b0, gmin} + {1'b0, k_margin};
  assign hi_mark  = level63(gmin, gmax);

  wfx_buffer #(.DW(DW), .DEPTH(N_SAMP), .AW(AW)) i_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (wr_addr),
    .wdata ({wr_gate, wr_vd, wr_id}),
    .raddr (cnt[AW-1:0]),
    .rdata (rdata)
  );

  wfx_stat_scan #(.SW(SW), .AW(AW), .CW(CW), .SUMW(SUMW)) i_stat (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr_stat),
    .vld      (d_vld && (state == ST_STAT)),
    .idx      (d_idx),
    .gate     (r_gate),
    .vd       (r_vd),
    .id       (r_id),
    .ilevel   (k_ilevel),
    .on_first (k_first),
    .on_last  (k_last),
    .gmin     (gmin),
    .gmax     (gmax),
    .hit      (s_hit),
    .vth      (s_vth),
    .sum_vd   (s_svd),
    .sum_id   (s_sid),
    .on_cnt   (s_cnt)
  );

  wfx_rise_scan #(.SW(SW), .AW(AW)) i_rise (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr_rise),
    .vld     (d_vld && (state == ST_TIME)),
    .idx     (d_idx),
    .gate    (r_gate),
    .lo_mark (lo_mark),
    .hi_mark (hi_mark),
    .found   (r_found),
    .tau     (r_tau)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      d_vld    <= 1'b0;
      d_idx    <= '0;
      k_margin <= '0;
      k_ilevel <= '0;
      k_first  <= '0;
      k_last   <= '0;
      done     <= 1'b0;
      tau      <= '0;
      tau_ok   <= 1'b0;
      vth      <= '0;
      vth_ok   <= 1'b0;
      sum_vd   <= '0;
      sum_id   <= '0;
      on_cnt   <= '0;
    end else begin
      d_vld <= issue;
      d_idx <= cnt[AW-1:0];
      done  <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state    <= ST_STAT;
          cnt      <= '0;
          k_margin <= cfg_margin;
          k_ilevel <= cfg_ilevel;
          k_first  <= cfg_on_first;
          k_last   <= cfg_on_last;
        end
        ST_STAT: begin
          if (issue) cnt <= cnt + 1'b1;
          else if (!d_vld) begin
            state <= ST_TIME;
            cnt   <= '0;
          end
        end
        ST_TIME: begin
          if (issue) cnt <= cnt + 1'b1;
          else if (!d_vld) state <= ST_FIN;
        end
        ST_FIN: begin
          state  <= ST_IDLE;
          done   <= 1'b1;
          tau    <= r_found ? r_tau : '0;
          tau_ok <= r_found;
          vth    <= s_hit ? s_vth : '0;
          vth_ok <= s_hit;
          sum_vd <= s_svd;
          sum_id <= s_sid;
          on_cnt <= s_cnt;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R2
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy));
  // R4
  span_order_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TIME) |-> (gmin <= gmax));
  // R6
  tau_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !tau_ok |-> (tau == '0));
  // R8
  vth_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !vth_ok |-> (vth == '0));
  // R9
  on_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    on_cnt <= CW'(N_SAMP));
endmodule

// File: tb/test_wfx_top.sv
module test_wfx_top;
  localparam int N    = 16;
  localparam int SW   = 16;
  localparam int AW   = 4;
  localparam int CW   = 5;
  localparam int SUMW = SW + CW;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_en = 1'b0;
  logic [AW-1:0]   wr_addr = '0;
  logic [SW-1:0]   wr_gate = '0, wr_vd = '0, wr_id = '0;
  logic            start = 1'b0;
  logic [SW-1:0]   cfg_margin = '0, cfg_ilevel = '0;
  logic [AW-1:0]   cfg_on_first = '0, cfg_on_last = '0;
  logic            busy, done, tau_ok, vth_ok;
  logic [AW-1:0]   tau;
  logic [SW-1:0]   vth;
  logic [SUMW-1:0] sum_vd, sum_id;
  logic [CW-1:0]   on_cnt;

  int checks = 0;
  int fails  = 0;
  int g_m[N], v_m[N], i_m[N];

  always #10 clk = ~clk;

  wfx_top #(.N_SAMP(N), .SW(SW)) i_wfx_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_gate(wr_gate), .wr_vd(wr_vd), .wr_id(wr_id), .start(start),
    .cfg_margin(cfg_margin), .cfg_ilevel(cfg_ilevel),
    .cfg_on_first(cfg_on_first), .cfg_on_last(cfg_on_last),
    .busy(busy), .done(done), .tau(tau), .tau_ok(tau_ok),
    .vth(vth), .vth_ok(vth_ok), .sum_vd(sum_vd), .sum_id(sum_id),
    .on_cnt(on_cnt)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int hsh(input int a);
    logic [31:0] x;
    x = a * 32'd1103515245 + 32'd12345;
    return int'(x[31:16]);
  endfunction

  task automatic gen(input int kind);
    for (int i = 0; i < N; i++) begin
      case (kind)
        0: begin
          g_m[i] = (i < 3) ? 1000 : ((1000 + (i - 3) * 3000 > 40000) ? 40000 : 1000 + (i - 3) * 3000);
          v_m[i] = 200 + i * 7; i_m[i] = i * 400;
        end
        1: begin g_m[i] = 5000; v_m[i] = hsh(i); i_m[i] = 100 * i; end
        2: begin g_m[i] = 52000 - (50000 >> i); v_m[i] = hsh(i + 50); i_m[i] = i * i * 250; end
        3: begin g_m[i] = hsh(i * 3 + 7); v_m[i] = hsh(i + 99); i_m[i] = hsh(i + 500); end
        4: begin g_m[i] = 60000 - i * 3000; v_m[i] = 65535; i_m[i] = 65535 - i * 1000; end
        default: begin
          g_m[i] = (i >= 8) ? 65535 : 0; v_m[i] = (i % 2 == 1) ? 65535 : 0; i_m[i] = g_m[i];
        end
      endcase
    end
  endtask

  task automatic load();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(i);
      wr_gate = SW'(g_m[i]); wr_vd = SW'(v_m[i]); wr_id = SW'(i_m[i]);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Reference results computed from the requirement text.
  task automatic run(input int margin, input int ilev, input int f, input int l, input bit disturb);
    int gmn, gmx, lvl, st, cr, e_tau, e_tok, e_vth, e_vok, e_svd, e_sid, e_cnt, n;
    gmn = 65535; gmx = 0;
    for (int i = 0; i < N; i++) begin
      if (g_m[i] < gmn) gmn = g_m[i];
      if (g_m[i] > gmx) gmx = g_m[i];
    end
    lvl = gmn + (((gmx - gmn) * 161) / 256);          // R4
    st = -1; cr = -1;
    for (int i = 0; i < N; i++) if (st < 0 && g_m[i] > gmn + margin) st = i;
    if (st >= 0) for (int i = st; i < N; i++) if (cr < 0 && g_m[i] >= lvl) cr = i;
    e_tok = (cr >= 0); e_tau = e_tok ? cr - st : 0;
    e_vok = 0; e_vth = 0;
    for (int i = 0; i < N; i++) if (!e_vok && i_m[i] >= ilev) begin e_vok = 1; e_vth = g_m[i]; end
    e_svd = 0; e_sid = 0; e_cnt = 0;
    for (int i = f; i <= l; i++) begin e_svd += v_m[i]; e_sid += i_m[i]; e_cnt++; end

    @(negedge clk);
    cfg_margin = SW'(margin); cfg_ilevel = SW'(ilev);
    cfg_on_first = AW'(f); cfg_on_last = AW'(l);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk("R2", "busy after start", busy, 1);
    n = 0;
    while (1) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (done || n > 200) break;
      if (disturb && n == 3) begin
        wr_en = 1'b1; wr_addr = '0; wr_gate = '1; wr_vd = '1; wr_id = '1;
        start = 1'b1; cfg_margin = 0; cfg_ilevel = 0; cfg_on_first = 0; cfg_on_last = AW'(N - 1);
      end
      if (disturb && n == 4) begin wr_en = 1'b0; start = 1'b0; end
    end
    chk("R2", "done latency", n, 2 * N + 5);
    chk("R2", "busy low with done", busy, 0);
    chk(disturb ? "R3" : "R5", "tau_ok", tau_ok, e_tok);
    chk(e_tok ? "R5" : "R6", "tau", tau, e_tau);
    chk(disturb ? "R3" : "R7", "vth_ok", vth_ok, e_vok);
    chk(e_vok ? "R7" : "R8", "vth", vth, e_vth);
    chk("R9", "sum_vd", sum_vd, e_svd);
    chk("R9", "sum_id", sum_id, e_sid);
    chk("R9", "on_cnt", on_cnt, e_cnt);
    @(negedge clk);
    chk("R2", "done single cycle", done, 0);
    chk("R2", "results held", on_cnt, e_cnt);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int mg[3], il[3], wf[4], wl[4];
    mg = '{0, 100, 30000};
    il = '{0, 3000, 65535};
    wf = '{0, 4, 10, 7};
    wl = '{15, 9, 3, 7};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "tau_ok", tau_ok, 0);
    chk("R1", "vth_ok", vth_ok, 0);
    chk("R1", "on_cnt", on_cnt, 0);
    chk("R1", "sum_vd", sum_vd, 0);
    for (int k = 0; k < 6; k++) begin
      gen(k);
      load();
      for (int a = 0; a < 3; a++)
        for (int b = 0; b < 3; b++)
          for (int w = 0; w < 4; w++)
            run(mg[a], il[b], wf[w], wl[w], 1'b0);
    end
    // R3: mid-scan writes, start and cfg changes ignored; rerun shows buffer intact
    gen(3);
    load();
    run(100, 40000, 4, 9, 1'b1);
    run(100, 40000, 4, 9, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule